// File: doc/BRIEF.md
# Shared-Port Bus Arbiter with Home Owner

This block lets a small number of Wishbone bus masters share one downstream slave port. One port, chosen by a parameter, is the home owner. It holds the grant whenever nobody else is asking for the bus. Because the grant is already in place, a transaction from the home port reaches the slave in the same cycle its cycle signal rises. No cycle is spent on arbitration.

The other ports win the bus at a transaction boundary. A master that owns the bus keeps it for as long as its cycle signal stays high. Once the owner releases, the grant goes to the home port if that port is requesting. Otherwise it goes to the lowest-numbered requesting port, and if no port is requesting it falls back to the home port. Acknowledge, error and read data from the slave are passed only to the current owner.

A typical use is a two-input instance that joins an instruction-side bus and a data-side bus in front of a shared memory. A three-input instance can sit on a data-side bus shared by a processor, a reconfigurable socket and a debug module. Address decoding and width or clock conversion are left to the surrounding logic.

Top module: `wb_home_arbiter`

## Requirements
- R1: After a synchronous active-high reset, the home port (parameter DEFAULT_PORT) owns the bus. With no requests, the downstream cycle signal is low.
- R2: While the home port owns the bus, raising its cycle signal drives the downstream cycle, strobe, address, write-enable, write data and byte selects in the same cycle. No wait cycle is added.
- R3: If the home port owns the bus and its cycle signal is low at a clock edge while another port requests, ownership moves to a requesting port at that edge. The new owner's request appears downstream in the next cycle.
- R4: When ownership is handed to a port other than the home port, the lowest-indexed requesting port is chosen.
- R5: While the owner's cycle signal is high, ownership does not change, whatever the other ports request.
- R6: At a clock edge where the owner's cycle signal is low, ownership goes to the home port if its cycle signal is high, or if no port requests at all. Only otherwise does it go to the port chosen by R4.
- R7: Slave acknowledge and error are routed only to the owning port. Every other port sees acknowledge 0, error 0 and read data 0. The owning port receives the slave read data unchanged.
- R8: The downstream request signals always equal those of the owning port. Bit group i of each flat master vector belongs to port i (for example address bits i*ADDR_W upward). The downstream cycle signal is low whenever the owner is not requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_cyc | input | NUM_PORTS | Cycle signal per master |
| m_stb | input | NUM_PORTS | Strobe per master |
| m_we | input | NUM_PORTS | Write enable per master |
| m_adr | input | NUM_PORTS*ADDR_W | Addresses, port i in slice i |
| m_dat_w | input | NUM_PORTS*DATA_W | Write data, port i in slice i |
| m_sel | input | NUM_PORTS*DATA_W/8 | Byte selects, port i in slice i |
| m_ack | output | NUM_PORTS | Acknowledge per master |
| m_err | output | NUM_PORTS | Error per master |
| m_dat_r | output | NUM_PORTS*DATA_W | Read data, port i in slice i |
| s_cyc | output | 1 | Downstream cycle |
| s_stb | output | 1 | Downstream strobe |
| s_we | output | 1 | Downstream write enable |
| s_adr | output | ADDR_W | Downstream address |
| s_dat_w | output | DATA_W | Downstream write data |
| s_sel | output | DATA_W/8 | Downstream byte selects |
| s_ack | input | 1 | Slave acknowledge |
| s_err | input | 1 | Slave error |
| s_dat_r | input | DATA_W | Slave read data |

## Verification
The bench uses three ports with the home port in the middle, at index 1. This separates "lowest index" from "not the home port".

A directed sequence covers four situations:
- the home port requesting alone;
- two non-home ports contending while the home port is idle;
- a held grant under pressure from all ports;
- a release while the home port and a non-home port are both waiting.

The bench then drives every ordered pair of the eight request patterns, followed by a long pseudo-random run. In each cycle a reference model in the bench predicts the owner, and the bench checks the downstream request and every per-port response against it. The pair sweep distinguishes hold from handover for every starting owner. The random run mixes acknowledges and errors, so misrouted responses show up.

// File: rtl/wbarb_pkg.sv
package wbarb_pkg;

    localparam int MAX_PORTS = 8;
    localparam int IDX_W     = 3;

    typedef logic [IDX_W-1:0] port_idx_t;

    typedef struct packed {
        logic ack;
        logic err;
    } rsp_flags_t;

    // Choose the next owner at a free edge: home first, then lowest other requester.
    function automatic port_idx_t pick_owner(input logic [MAX_PORTS-1:0] req,
                                             input port_idx_t home,
                                             input int nports);
        port_idx_t sel;
        logic      found;
        sel   = home;
        found = req[home];
        for (int i = 0; i < MAX_PORTS; i++) begin
            if (!found && i < nports && port_idx_t'(i) != home && req[i]) begin
                sel   = port_idx_t'(i);
                found = 1'b1;
            end
        end
        return sel;
    endfunction

endpackage

// File: rtl/wbarb_grant.sv
module wbarb_grant
    import wbarb_pkg::*;
#(
    parameter int NPORT    = 3,
    parameter int DEF_PORT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] cyc_in,
    output port_idx_t        owner,
    output logic [NPORT-1:0] grant
);
    localparam port_idx_t HOME = port_idx_t'(DEF_PORT);

    logic [MAX_PORTS-1:0] req_pad;
    port_idx_t            owner_q;
    port_idx_t            owner_d;
    logic                 owner_busy;

    always_comb begin
        req_pad            = '0;
        req_pad[NPORT-1:0] = cyc_in;
    end

    always_comb begin
        owner_busy = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            if (owner_q == port_idx_t'(i)) owner_busy = cyc_in[i];
        end
    end

    always_comb begin
        if (owner_busy) owner_d = owner_q;
        else            owner_d = pick_owner(req_pad, HOME, NPORT);
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= HOME;
        else     owner_q <= owner_d;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_grant
        assign grant[g] = (owner_q == port_idx_t'(g));
    end

    assign owner = owner_q;

    // R5
    owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
        owner_busy |=> (owner_q == $past(owner_q)));

    // R6
    idle_home_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_in == '0) |=> (owner_q == HOME));

    // R1
    grant_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(grant) == 1);

endmodule

// File: rtl/wbarb_req_mux.sv
module wbarb_req_mux
    import wbarb_pkg::*;
#(
    parameter int NPORT  = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  port_idx_t                  owner,
    input  logic [NPORT-1:0]           m_cyc,
    input  logic [NPORT-1:0]           m_stb,
    input  logic [NPORT-1:0]           m_we,
    input  logic [NPORT*ADDR_W-1:0]    m_adr,
    input  logic [NPORT*DATA_W-1:0]    m_dat_w,
    input  logic [NPORT*DATA_W/8-1:0]  m_sel,
    output logic                       s_cyc,
    output logic                       s_stb,
    output logic                       s_we,
    output logic [ADDR_W-1:0]          s_adr,
    output logic [DATA_W-1:0]          s_dat_w,
    output logic [DATA_W/8-1:0]        s_sel
);
    localparam int SEL_W = DATA_W / 8;

    always_comb begin
        s_cyc   = 1'b0;
        s_stb   = 1'b0;
        s_we    = 1'b0;
        s_adr   = '0;
        s_dat_w = '0;
        s_sel   = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (owner == port_idx_t'(i)) begin
                s_cyc   = m_cyc[i];
                s_stb   = m_stb[i];
                s_we    = m_we[i];
                s_adr   = m_adr[i*ADDR_W +: ADDR_W];
                s_dat_w = m_dat_w[i*DATA_W +: DATA_W];
                s_sel   = m_sel[i*SEL_W +: SEL_W];
            end
        end
    end

endmodule

// File: rtl/wbarb_rsp_route.sv
module wbarb_rsp_route
    import wbarb_pkg::*;
#(
    parameter int NPORT  = 3,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT-1:0]        grant,
    input  logic                    s_ack,
    input  logic                    s_err,
    input  logic [DATA_W-1:0]       s_dat_r,
    output logic [NPORT-1:0]        m_ack,
    output logic [NPORT-1:0]        m_err,
    output logic [NPORT*DATA_W-1:0] m_dat_r
);
    rsp_flags_t flags;

    assign flags = '{ack: s_ack, err: s_err};

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign m_ack[g]                    = grant[g] & flags.ack;
        assign m_err[g]                    = grant[g] & flags.err;
        assign m_dat_r[g*DATA_W +: DATA_W] = grant[g] ? s_dat_r : '0;
    end

    // R7
    resp_single_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(m_ack) <= 1) && ($countones(m_err) <= 1));

endmodule

// File: rtl/wb_home_arbiter.sv
module wb_home_arbiter
    import wbarb_pkg::*;
#(
    parameter int NUM_PORTS    = 3,
    parameter int DEFAULT_PORT = 0,
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_PORTS-1:0]            m_cyc,
    input  logic [NUM_PORTS-1:0]            m_stb,
    input  logic [NUM_PORTS-1:0]            m_we,
    input  logic [NUM_PORTS*ADDR_W-1:0]     m_adr,
    input  logic [NUM_PORTS*DATA_W-1:0]     m_dat_w,
    input  logic [NUM_PORTS*DATA_W/8-1:0]   m_sel,
    output logic [NUM_PORTS-1:0]            m_ack,
    output logic [NUM_PORTS-1:0]            m_err,
    output logic [NUM_PORTS*DATA_W-1:0]     m_dat_r,
    output logic                            s_cyc,
    output logic                            s_stb,
    output logic                            s_we,
    output logic [ADDR_W-1:0]               s_adr,
    output logic [DATA_W-1:0]               s_dat_w,
    output logic [DATA_W/8-1:0]             s_sel,
    input  logic                            s_ack,
    input  logic                            s_err,
    input  logic [DATA_W-1:0]               s_dat_r
);
    localparam port_idx_t            HOME      = port_idx_t'(DEFAULT_PORT);
    localparam logic [NUM_PORTS-1:0] HOME_MASK = NUM_PORTS'(1) << DEFAULT_PORT;

    port_idx_t              owner;
    logic [NUM_PORTS-1:0]   grant;

    wbarb_grant #(
        .NPORT    (NUM_PORTS),
        .DEF_PORT (DEFAULT_PORT)
    ) u_grant (
        .clk    (clk),
        .rst    (rst),
        .cyc_in (m_cyc),
        .owner  (owner),
        .grant  (grant)
    );

    wbarb_req_mux #(
        .NPORT  (NUM_PORTS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_req (
        .owner   (owner),
        .m_cyc   (m_cyc),
        .m_stb   (m_stb),
        .m_we    (m_we),
        .m_adr   (m_adr),
        .m_dat_w (m_dat_w),
        .m_sel   (m_sel),
        .s_cyc   (s_cyc),
        .s_stb   (s_stb),
        .s_we    (s_we),
        .s_adr   (s_adr),
        .s_dat_w (s_dat_w),
        .s_sel   (s_sel)
    );

    wbarb_rsp_route #(
        .NPORT  (NUM_PORTS),
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk     (clk),
        .rst     (rst),
        .grant   (grant),
        .s_ack   (s_ack),
        .s_err   (s_err),
        .s_dat_r (s_dat_r),
        .m_ack   (m_ack),
        .m_err   (m_err),
        .m_dat_r (m_dat_r)
    );

    // R2
    home_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (owner == HOME && m_cyc[DEFAULT_PORT])
            |-> (s_cyc && s_adr == m_adr[DEFAULT_PORT*ADDR_W +: ADDR_W]));

    // R3
    preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (owner == HOME && !m_cyc[DEFAULT_PORT] && ((m_cyc & ~HOME_MASK) != '0))
            |=> (owner != HOME));

endmodule

// File: tb/wb_home_arbiter_tb.sv
`timescale 1ns/1ps
module wb_home_arbiter_tb;

    localparam int N    = 3;
    localparam int HOME = 1;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int SW   = DW / 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    m_cyc = '0, m_stb = '0, m_we = '0;
    logic [N*AW-1:0] m_adr;
    logic [N*DW-1:0] m_dat_w;
    logic [N*SW-1:0] m_sel;
    logic [N-1:0]    m_ack, m_err;
    logic [N*DW-1:0] m_dat_r;
    logic            s_cyc, s_stb, s_we;
    logic [AW-1:0]   s_adr;
    logic [DW-1:0]   s_dat_w;
    logic [SW-1:0]   s_sel;
    logic            s_ack = 1'b0, s_err = 1'b0;
    logic [DW-1:0]   s_dat_r = '0;

    int total = 0;
    int bad   = 0;
    int mo    = HOME;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    wb_home_arbiter #(
        .NUM_PORTS(N), .DEFAULT_PORT(HOME), .ADDR_W(AW), .DATA_W(DW)
    ) u_dut (
        .clk(clk), .rst(rst),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr),
        .m_dat_w(m_dat_w), .m_sel(m_sel), .m_ack(m_ack), .m_err(m_err),
        .m_dat_r(m_dat_r), .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we),
        .s_adr(s_adr), .s_dat_w(s_dat_w), .s_sel(s_sel),
        .s_ack(s_ack), .s_err(s_err), .s_dat_r(s_dat_r)
    );

    function automatic logic [AW-1:0] adr_of(int i);
        return 32'h1000_0000 * (i + 1) + 32'h44;
    endfunction
    function automatic logic [DW-1:0] dat_of(int i);
        return 32'hC0DE_0000 | i;
    endfunction

    function automatic int next_owner(int cur, logic [N-1:0] c);
        if (c[cur])  return cur;
        if (c[HOME]) return HOME;
        for (int i = 0; i < N; i++) if (i != HOME && c[i]) return i;
        return HOME;
    endfunction

    task automatic chk(input bit ok, input string tag, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic step(input logic [N-1:0] c, input logic ack, input logic err,
                        input string tag);
        logic [N-1:0]    ea, ee;
        logic [N*DW-1:0] ed;
        @(negedge clk);
        m_cyc   = c;
        m_stb   = c;
        s_ack   = ack;
        s_err   = err;
        s_dat_r = 32'h5A5A_0000 ^ {16'd0, 8'(total), 5'd0, 3'(c)};
        #1;
        chk(s_cyc == c[mo] && s_stb == c[mo] && s_we == m_we[mo] &&
            s_adr == adr_of(mo) && s_dat_w == dat_of(mo) && s_sel == SW'(1 << mo),
            tag, $sformatf("req owner=%0d actual cyc=%b adr=%h expected cyc=%b adr=%h",
                           mo, s_cyc, s_adr, c[mo], adr_of(mo)));
        ea = '0; ee = '0; ed = '0;
        ea[mo] = ack;
        ee[mo] = err;
        ed[mo*DW +: DW] = s_dat_r;
        chk(m_ack == ea && m_err == ee && m_dat_r == ed,
            tag, $sformatf("rsp actual ack=%b err=%b dat=%h expected ack=%b err=%b dat=%h",
                           m_ack, m_err, m_dat_r, ea, ee, ed));
        @(posedge clk);
        mo = next_owner(mo, c);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_adr[i*AW +: AW]   = adr_of(i);
            m_dat_w[i*DW +: DW] = dat_of(i);
            m_sel[i*SW +: SW]   = SW'(1 << i);
        end
        m_we = 3'b101;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mo  = HOME;

        step(3'b000, 1'b0, 1'b0, "R1 idle after reset");
        step(3'b010, 1'b1, 1'b0, "R2 home passes same cycle");
        step(3'b010, 1'b0, 1'b0, "R2 home held");
        step(3'b101, 1'b0, 1'b0, "R3 others request while home idle");
        step(3'b101, 1'b1, 1'b0, "R4 lowest other port wins");
        step(3'b111, 1'b0, 1'b1, "R5 grant held under contention");
        step(3'b110, 1'b0, 1'b0, "R6 release with home waiting");
        step(3'b110, 1'b1, 1'b0, "R6 home regains");
        step(3'b100, 1'b0, 1'b0, "R4 port 2 after home");
        step(3'b100, 1'b1, 1'b0, "R7 response to port 2 only");
        step(3'b000, 1'b0, 1'b0, "R6 return home when idle");
        step(3'b011, 1'b1, 1'b1, "R2 simultaneous arrival home wins");

        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                step(3'(a), a[0], b[0], "R8 pattern pairs");
                step(3'(b), b[1], a[1], "R5 pattern pairs");
            end
        end

        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int k = 0; k < 3000; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[2:0], lfsr[5], lfsr[9], "R7 random run");
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL all: watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule